// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on one output line. Bytes enter through a valid/ready stream port and wait in a 16-entry first-in first-out queue. A frame sequencer takes them from the queue one at a time and sends each as a framed character. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. While the queue holds bytes, characters follow each other with no idle time between them. When there is nothing to send, the line rests high.

Bit timing comes from an external enable pulse, `tick`, that runs at 16 or 8 times the bit rate. Each bit lasts exactly 16 or 8 of those pulses. Static configuration pins set the oversampling ratio, the data width (7 or 8 bits), whether parity is sent, the parity sense and the number of stop bits. Change them only while `tx_end` is high.

Back-pressure rules for the input stream: a byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while the queue is full. A source must hold its byte until it sees `in_ready`. If it asserts `in_valid` while `in_ready` is low, the byte is thrown away and a sticky overflow flag is raised. Pulsing `ovf_clr` clears that flag.

Top module: `sertx_top`

## Requirements
- R1: After reset the outputs are as follows: `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0, `fifo_count` is 0, `tx_end` is 1 and `ovf` is 0. `txd` stays 1 whenever no character is being sent.
- R2: A character is sent in this order: one start bit at 0, the data bits with bit 0 first, the parity bit if enabled, then the stop bits at 1.
- R3: When `cfg_data7`=1, only data bits 0 to 6 are sent and bit 7 of the byte has no effect on the line. When `cfg_data7`=0, all 8 bits are sent.
- R4: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 (even), it equals the XOR of the configured data bits. With `cfg_par_odd`=1 (odd), it is the inverse of that XOR. When `cfg_par_en`=0, no parity bit is sent.
- R5: When `cfg_stop2`=0, one stop bit is sent. When `cfg_stop2`=1, two stop bits are sent.
- R6: When `cfg_os8`=0, every bit lasts 16 `tick` pulses. When `cfg_os8`=1, every bit lasts 8. The bit period begins counting on the clock after the bit starts. Ticks seen while idle have no effect.
- R7: If the queue is not empty when the last stop bit completes, the next start bit begins on the following clock, with no idle bit in between.
- R8: A byte is accepted when `in_valid` and `in_ready` are both high. The queue holds 16 bytes and sends them in arrival order. `fifo_count` gives the number of stored bytes. `fifo_full` means the count is 16, `fifo_empty` means it is 0, and `in_ready` equals the inverse of `fifo_full`.
- R9: If a byte is accepted at clock edge t while the block is idle with an empty queue, `txd` goes to 0 after edge t+1.
- R10: `tx_end` is 1 exactly when no character is being sent and the queue is empty.
- R11: If `in_valid` is high while `in_ready` is low, the byte is discarded and `ovf` becomes 1 after that edge. `ovf` stays 1 until an edge where `ovf_clr` is 1. If a new overflow occurs at the same edge as `ovf_clr`, the overflow takes priority and `ovf` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Bit-timing enable, 16x or 8x the bit rate |
| cfg_os8 | input | 1 | 1: 8 ticks per bit; 0: 16 ticks per bit |
| cfg_data7 | input | 1 | 1: 7 data bits; 0: 8 data bits |
| cfg_par_en | input | 1 | 1: send parity bit |
| cfg_par_odd | input | 1 | 1: odd parity; 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits; 0: one |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Queue can accept a byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| txd | output | 1 | Serial output line |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_count | output | 5 | Number of bytes in the queue |
| tx_end | output | 1 | Idle with an empty queue |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong bit counter or tick counter makes a bit too long or too short. A wrong shift state sends the wrong data or parity. A sequencer that stalls between characters inserts a gap. Each of these changes the value of `txd` on some clock within one bit period of the fault, so a reference model compared against `txd` every clock exposes it at once. Bad queue pointers or a bad count show up at once in `fifo_count`, `fifo_full` and `in_ready`. A byte that is lost or sent twice shows up at the latest when its own frame would begin.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } fr_state_t;

  // Parity over the configured data bits; odd sense inverts the XOR.
  function automatic logic frame_parity(input logic [DATA_W-1:0] d,
                                        input logic seven,
                                        input logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (seven) m[DATA_W-1] = 1'b0;
    return (^m) ^ odd;
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_pop,
  input  logic          ovf_clr,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push    = wr_valid && !full;
  assign pop     = rd_pop && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_valid && full) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8,
  localparam int TW   = $clog2(OS_HI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_os8,
  input  logic              cfg_data7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic [DATA_W-1:0] head_data,
  input  logic              q_empty,
  output logic              pop,
  output logic              txd,
  output logic              idle
);
  fr_state_t         state;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic [TW-1:0]     tcnt;
  logic [2:0]        bitcnt;
  logic [TW-1:0]     tlast;
  logic [2:0]        dlast;
  logic              bit_done, frame_end;

  assign tlast     = cfg_os8 ? TW'(OS_LO - 1) : TW'(OS_HI - 1);
  assign dlast     = cfg_data7 ? 3'd6 : 3'd7;
  assign bit_done  = (state != S_IDLE) && tick && (tcnt == tlast);
  assign frame_end = (state == S_STOP) && bit_done &&
                     (bitcnt == (cfg_stop2 ? 3'd1 : 3'd0));
  assign pop       = !q_empty && ((state == S_IDLE) || frame_end);
  assign idle      = (state == S_IDLE);

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = shreg[0];
      S_PAR:   txd = par_bit;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      shreg   <= '0;
      par_bit <= 1'b0;
      tcnt    <= '0;
      bitcnt  <= '0;
    end else if (pop) begin
      state   <= S_START;
      shreg   <= head_data;
      par_bit <= frame_parity(head_data, cfg_data7, cfg_par_odd);
      tcnt    <= '0;
      bitcnt  <= '0;
    end else begin
      if (state != S_IDLE && tick) tcnt <= bit_done ? '0 : tcnt + 1'b1;
      if (bit_done) begin
        case (state)
          S_START: begin
            state  <= S_DATA;
            bitcnt <= '0;
          end
          S_DATA: begin
            shreg <= shreg >> 1;
            if (bitcnt == dlast) begin
              state  <= cfg_par_en ? S_PAR : S_STOP;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_PAR: begin
            state  <= S_STOP;
            bitcnt <= '0;
          end
          S_STOP: begin
            if (frame_end) state <= S_IDLE;
            else           bitcnt <= bitcnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OS_HI = 16,
  parameter int OS_LO = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_os8,
  input  logic              cfg_data7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ovf_clr,
  output logic              txd,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [CW-1:0]     fifo_count,
  output logic              tx_end,
  output logic              ovf
);
  logic [DATA_W-1:0] head;
  logic              pop, idle;

  sertx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_data  (in_data),
    .rd_pop   (pop),
    .ovf_clr  (ovf_clr),
    .rd_data  (head),
    .count    (fifo_count),
    .full     (fifo_full),
    .empty    (fifo_empty),
    .ovf      (ovf)
  );

  sertx_framer #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cfg_os8     (cfg_os8),
    .cfg_data7   (cfg_data7),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop2   (cfg_stop2),
    .head_data   (head),
    .q_empty     (fifo_empty),
    .pop         (pop),
    .txd         (txd),
    .idle        (idle)
  );

  assign in_ready = !fifo_full;
  assign tx_end   = idle && fifo_empty;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          ovf_clr,
  input logic          txd,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_count,
  input logic          tx_end,
  input logic          ovf
);
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> txd);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  p_push_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !fifo_empty);

  p_start_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && tx_end) |=> ##1 !txd);

  p_ovf_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovf);

  p_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
endmodule

bind sertx_top sertx_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_os8 = 1'b0, cfg_data7 = 1'b0, cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       ovf_clr = 1'b0;
  logic       in_ready, txd, fifo_full, fifo_empty, tx_end, ovf;
  logic [4:0] fifo_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_os8(cfg_os8), .cfg_data7(cfg_data7), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ovf_clr(ovf_clr), .txd(txd), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count),
    .tx_end(tx_end), .ovf(ovf)
  );

  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] mq[$];
  bit         mframe[$];
  bit         m_active;
  int         m_bit, m_tk;
  bit         m_ovf;

  function automatic void load_frame(input logic [7:0] d);
    int n;
    int ones;
    n = cfg_data7 ? 7 : 8;
    ones = 0;
    mframe.delete();
    mframe.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      mframe.push_back(d[i]);
      if (d[i]) ones++;
    end
    if (cfg_par_en) mframe.push_back(((ones % 2) == 1) ^ cfg_par_odd);
    mframe.push_back(1'b1);
    if (cfg_stop2) mframe.push_back(1'b1);
    m_active = 1'b1;
    m_bit = 0;
    m_tk = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_active = 1'b0;
      m_bit = 0;
      m_tk = 0;
      m_ovf = 1'b0;
    end else begin
      bit was_full;
      int per;
      was_full = (mq.size() >= 16);
      per = cfg_os8 ? 8 : 16;
      if (!m_active) begin
        if (mq.size() > 0) load_frame(mq.pop_front());
      end else if (tick) begin
        m_tk++;
        if (m_tk == per) begin
          m_tk = 0;
          m_bit++;
          if (m_bit == mframe.size()) begin
            if (mq.size() > 0) load_frame(mq.pop_front());
            else m_active = 1'b0;
          end
        end
      end
      if (in_valid && !was_full) mq.push_back(in_data);
      if (in_valid && was_full) m_ovf = 1'b1;
      else if (ovf_clr) m_ovf = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // compare every clock, then drive the tick for the next edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int etx;
      int cnt;
      etx = m_active ? int'(mframe[m_bit]) : 1;
      cnt = mq.size();
      check("R2/R3/R4/R5/R6/R7/R9 txd", int'(txd), etx);
      check("R8 fifo_count", int'(fifo_count), cnt);
      check("R8 fifo_full", int'(fifo_full), int'(cnt == 16));
      check("R8 fifo_empty", int'(fifo_empty), int'(cnt == 0));
      check("R8 in_ready", int'(in_ready), int'(cnt != 16));
      check("R10 tx_end", int'(tx_end), int'(!m_active && cnt == 0));
      check("R11 ovf", int'(ovf), int'(m_ovf));
      if (!m_active) check("R1 idle line", int'(txd), 1);
    end
    tick = ((cyc % 3) == 0);
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_end) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic set_cfg(input bit os8, input bit d7, input bit pe,
                         input bit po, input bit s2);
    @(negedge clk);
    cfg_os8 = os8; cfg_data7 = d7; cfg_par_en = pe;
    cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 explicit reset state
    check("R1 reset txd", int'(txd), 1);
    check("R1 reset empty", int'(fifo_empty), 1);
    check("R1 reset count", int'(fifo_count), 0);
    check("R1 reset tx_end", int'(tx_end), 1);
    check("R1 reset ovf", int'(ovf), 0);

    // 8N1, 16x (R2, R6)
    set_cfg(0, 0, 0, 0, 0);
    send(8'hA5);
    wait_idle();

    // 8 data, even parity, two stops, 16x (R4, R5)
    set_cfg(0, 0, 1, 0, 1);
    send(8'h3C);
    send(8'h01);
    wait_idle();

    // 7 data, odd parity, one stop, 8x: bit 7 ignored (R3, R4, R6)
    set_cfg(1, 1, 1, 1, 0);
    send(8'hFF);
    send(8'h80);
    wait_idle();

    // 7 data, even parity, two stops, 16x
    set_cfg(0, 1, 1, 0, 1);
    send(8'h55);
    wait_idle();

    // back-to-back burst, 8O2 at 8x: no gap between frames (R7)
    set_cfg(1, 0, 1, 1, 1);
    for (int i = 0; i < 6; i++) send(8'(8'h11 * (i + 1)));
    wait_idle();

    // overflow: hold valid regardless of ready (R8, R11)
    set_cfg(1, 0, 0, 0, 0);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      in_valid = 1'b1;
      in_data = 8'(8'hC0 + i);
      ovf_clr = (i == 18);   // clear collides with overflow: set wins (R11)
      @(negedge clk);
    end
    in_valid = 1'b0;
    ovf_clr = 1'b0;
    check("R8 full after burst", int'(fifo_full), 1);
    check("R11 ovf after drop", int'(ovf), 1);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R11 ovf cleared", int'(ovf), 0);
    wait_idle();
    check("R10 tx_end at end", int'(tx_end), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule